// File: doc/BRIEF.md
# Serial Control Register Port

This block gives a host processor access to sixteen 10-bit configuration registers through a four-wire serial link. The wires are a serial clock, an active-low select, a data input and a data output. Every transfer is a 16-bit command word, sent most significant bit first. The top four bits pick a register and the next bit picks the direction. The following bit carries no meaning. The low ten bits are the payload. A write updates the chosen register when the select is released. A read queues the register's contents, and these shift out during the next transfer.

Several of these ports can share one host link in either of two ways, chosen by a static mode input. In chained mode, the data output carries the shift register onward to the next device. The output is always driven, and a transfer of 16·N clocks reaches every device in the chain. In shared-bus mode, each device has its own select. The output enable drops whenever the device is not selected, so the pad can float. The serial lines are oversampled on the block clock, and the whole register bank is exposed as one flat parallel vector for the logic it configures.

Top module: `serreg_port`

## Requirements
- R1: After reset every register reads zero on `regs_o`, and with `chain_mode` low `sdo_oe` is low.
- R2: A 16-bit frame, MSB first, is decoded as bits 15..12 address, bit 11 direction (0 write, 1 read), bit 10 ignored, bits 9..0 data. A write frame stores the data in the addressed register when `latch_n` returns high.
- R3: Addresses 9, 10, 14 and 15 are reserved. Writes to them leave `regs_o` unchanged, and reads of them return a data field of zero.
- R4: After an accepted read frame, the next frame shifts out {address, 1, 0, register value} MSB first. The first bit is valid before the first rising `sclk`. After any non-read frame, the next frame shifts out zeros.
- R5: With `chain_mode` low, a frame whose count of rising `sclk` edges is not exactly 16 (including zero) is discarded.
- R6: While `latch_n` is high, edges on `sclk` and changes on `sdi` change neither the registers nor the contents of a later frame.
- R7: With `chain_mode` low, `sdo_oe` is high exactly while the device is selected.
- R8: With `chain_mode` high, `sdo_oe` stays high. `sdo` repeats the `sdi` stream delayed by 16 clocks. A frame of 16 or more clocks applies its last 16 bits, and a frame of fewer than 16 clocks is discarded.
- R9: A write to address 0 with data bit 9 set returns every register, including register 0, to its reset value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock that oversamples the serial lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| chain_mode | input | 1 | 1 selects chained cascading, 0 selects shared-bus cascading |
| sclk | input | 1 | Serial clock: data in on its rising edge, data out after its falling edge |
| latch_n | input | 1 | Active-low frame select |
| sdi | input | 1 | Serial command input |
| sdo | output | 1 | Serial readback or pass-through output |
| sdo_oe | output | 1 | Output enable for the `sdo` pad driver |
| regs_o | output | 160 | All sixteen registers, register k at bits 10k+9..10k |

## Verification
The bench builds the block with its default parameters: two synchroniser stages, the reserved set {9, 10, 14, 15} and all-zero reset values. With only sixteen addresses, the sweep can write a distinct value to every address and read every address back, reserved ones included. The bench also runs frame lengths of 0, 15, 16, 17 and 32 clocks in both cascading modes. Because the reset values are zero, the software-reset result can be predicted exactly from the address map alone.

// File: rtl/serreg_pkg.sv
package serreg_pkg;
    localparam int ADDR_W  = 4;
    localparam int DATA_W  = 10;
    localparam int FRAME_W = ADDR_W + 2 + DATA_W;
    localparam int NREG    = 1 << ADDR_W;
    localparam int CNT_W   = $clog2(FRAME_W + 2);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              rd;
        logic              rsv;
        logic [DATA_W-1:0] data;
    } cmd_t;

    typedef logic [NREG-1:0][DATA_W-1:0] bank_t;
endpackage

// File: rtl/serreg_sync.sv
module serreg_sync #(
    parameter int               WIDTH   = 3,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [STAGES-1:0][WIDTH-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d[0] = d_i;
        for (int s = 1; s < STAGES; s++) begin
            pipe_d[s] = pipe_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= {STAGES{RST_VAL}};
        else        pipe_q <= pipe_d;
    end

    assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/serreg_shift.sv
module serreg_shift
    import serreg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_s,
    input  logic latch_s,
    input  logic sdi_s,
    input  logic chain_mode,
    input  cmd_t rd_word,
    output logic start_o,
    output logic cmd_vld_o,
    output cmd_t cmd_o,
    output logic sdo_o,
    output logic sdo_oe_o
);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(FRAME_W);
    localparam logic [CNT_W-1:0] SAT  = CNT_W'(FRAME_W + 1);

    typedef struct packed {
        logic               sclk_prev;
        logic               latch_prev;
        logic [FRAME_W-1:0] sr;
        logic [CNT_W-1:0]   cnt;
        logic               sdo;
        logic               vld;
        cmd_t               cmd;
    } shift_st_t;

    shift_st_t s_d, s_q;
    logic rise, fall, lat_fall, lat_rise, frame_ok;
    logic [FRAME_W-1:0] rd_bits;

    always_comb begin
        s_d            = s_q;
        s_d.sclk_prev  = sclk_s;
        s_d.latch_prev = latch_s;
        s_d.vld        = 1'b0;
        rd_bits        = rd_word;
        rise     = sclk_s & ~s_q.sclk_prev;
        fall     = ~sclk_s & s_q.sclk_prev;
        lat_fall = s_q.latch_prev & ~latch_s;
        lat_rise = ~s_q.latch_prev & latch_s;
        frame_ok = chain_mode ? (s_q.cnt >= FULL) : (s_q.cnt == FULL);

        if (lat_fall) begin
            // preload queued readback so its MSB is visible before the first clock
            s_d.sr  = rd_bits;
            s_d.cnt = '0;
            s_d.sdo = rd_bits[FRAME_W-1];
        end else if (!latch_s) begin
            if (rise) begin
                s_d.sr  = {s_q.sr[FRAME_W-2:0], sdi_s};
                s_d.cnt = (s_q.cnt == SAT) ? SAT : s_q.cnt + 1'b1;
            end
            if (fall) begin
                s_d.sdo = s_q.sr[FRAME_W-1];
            end
        end

        if (lat_rise && frame_ok) begin
            s_d.vld = 1'b1;
            s_d.cmd = cmd_t'(s_q.sr);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q            <= '0;
            s_q.latch_prev <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign start_o   = lat_fall;
    assign cmd_vld_o = s_q.vld;
    assign cmd_o     = s_q.cmd;
    assign sdo_o     = s_q.sdo;
    assign sdo_oe_o  = chain_mode | ~latch_s;
endmodule

// File: rtl/serreg_bank.sv
module serreg_bank
    import serreg_pkg::*;
#(
    parameter logic [NREG-1:0] RSVD_MASK  = 16'hC600,
    parameter bank_t           DEFAULTS   = '0,
    parameter int              SWRST_ADDR = 0,
    parameter int              SWRST_BIT  = DATA_W - 1
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  start_i,
    input  logic  cmd_vld_i,
    input  cmd_t  cmd_i,
    output cmd_t  rd_word_o,
    output bank_t regs_o
);
    typedef struct packed {
        bank_t regs;
        cmd_t  rd_word;
    } bank_st_t;

    bank_st_t s_d, s_q;
    logic unused_rsv;
    assign unused_rsv = cmd_i.rsv;

    always_comb begin
        s_d = s_q;
        if (start_i) s_d.rd_word = '0;
        if (cmd_vld_i) begin
            if (cmd_i.rd) begin
                s_d.rd_word.addr = cmd_i.addr;
                s_d.rd_word.rd   = 1'b1;
                s_d.rd_word.rsv  = 1'b0;
                s_d.rd_word.data = RSVD_MASK[cmd_i.addr] ? '0 : s_q.regs[cmd_i.addr];
            end else if (!RSVD_MASK[cmd_i.addr]) begin
                if (cmd_i.addr == ADDR_W'(SWRST_ADDR) && cmd_i.data[SWRST_BIT])
                    s_d.regs = DEFAULTS;
                else
                    s_d.regs[cmd_i.addr] = cmd_i.data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.regs    <= DEFAULTS;
            s_q.rd_word <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign rd_word_o = s_q.rd_word;
    assign regs_o    = s_q.regs;
endmodule

// File: rtl/serreg_port.sv
module serreg_port
    import serreg_pkg::*;
#(
    parameter int              SYNC_STAGES = 2,
    parameter logic [NREG-1:0] RSVD_MASK   = 16'hC600,
    parameter bank_t           DEFAULTS    = '0
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     chain_mode,
    input  logic                     sclk,
    input  logic                     latch_n,
    input  logic                     sdi,
    output logic                     sdo,
    output logic                     sdo_oe,
    output logic [NREG*DATA_W-1:0]   regs_o
);
    logic [2:0] line_raw, line_s;
    logic       start, cmd_vld;
    cmd_t       cmd_word, rd_word;
    bank_t      bank_regs;

    assign line_raw = {sclk, latch_n, sdi};

    serreg_sync #(
        .WIDTH  (3),
        .STAGES (SYNC_STAGES),
        .RST_VAL(3'b010)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d_i  (line_raw),
        .q_o  (line_s)
    );

    serreg_shift u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk_s    (line_s[2]),
        .latch_s   (line_s[1]),
        .sdi_s     (line_s[0]),
        .chain_mode(chain_mode),
        .rd_word   (rd_word),
        .start_o   (start),
        .cmd_vld_o (cmd_vld),
        .cmd_o     (cmd_word),
        .sdo_o     (sdo),
        .sdo_oe_o  (sdo_oe)
    );

    serreg_bank #(
        .RSVD_MASK(RSVD_MASK),
        .DEFAULTS (DEFAULTS)
    ) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start),
        .cmd_vld_i(cmd_vld),
        .cmd_i    (cmd_word),
        .rd_word_o(rd_word),
        .regs_o   (bank_regs)
    );

    assign regs_o = bank_regs;
endmodule

// File: rtl/serreg_checks.sv
module serreg_checks
    import serreg_pkg::*;
#(
    parameter logic [NREG-1:0] RSVD_MASK = 16'hC600,
    parameter bank_t           DEFAULTS  = '0
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   chain_mode,
    input logic                   latch_n,
    input logic                   sdo_oe,
    input logic [NREG*DATA_W-1:0] regs_o,
    input logic                   cmd_vld,
    input cmd_t                   cmd_word
);
    logic [1:0] age;
    logic unused_rsv;
    assign unused_rsv = cmd_word.rsv;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          age <= '0;
        else if (age != 2'd3) age <= age + 2'd1;
    end

    // R2: the bank moves only one cycle after an accepted command
    a_r2_hold_without_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_vld |=> $stable(regs_o));

    // R4: a read command never alters the bank
    a_r4_read_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_vld && cmd_word.rd) |=> $stable(regs_o));

    // R9: software reset restores the whole bank
    a_r9_soft_reset: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_vld && !cmd_word.rd && cmd_word.addr == '0 && cmd_word.data[DATA_W-1])
        |=> (regs_o == DEFAULTS));

    // R7: deselected shared-bus device floats its output
    a_r7_float_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (age == 2'd3 && !chain_mode && latch_n && $past(latch_n) && $past(latch_n, 2))
        |-> !sdo_oe);

    // R8: chained device always drives
    a_r8_chain_drives: assert property (@(posedge clk) disable iff (!rst_n)
        chain_mode |-> sdo_oe);

    // R3: reserved slots keep their reset value
    for (genvar g = 0; g < NREG; g++) begin : g_rsvd
        if (RSVD_MASK[g]) begin : g_on
            a_r3_reserved_default: assert property (@(posedge clk) disable iff (!rst_n)
                regs_o[g*DATA_W +: DATA_W] == DEFAULTS[g]);
        end
    end
endmodule

bind serreg_port serreg_checks u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .chain_mode(chain_mode),
    .latch_n   (latch_n),
    .sdo_oe    (sdo_oe),
    .regs_o    (regs_o),
    .cmd_vld   (cmd_vld),
    .cmd_word  (cmd_word)
);

// File: tb/test_serreg_port.sv
module test_serreg_port;
    import serreg_pkg::*;

    localparam int H = 6;
    localparam logic [15:0] RSV = 16'hC600;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst_n = 1'b0, chain_mode = 1'b0, sclk = 1'b0, latch_n = 1'b1, sdi = 1'b0;
    logic sdo, sdo_oe;
    logic [NREG*DATA_W-1:0] regs_o;

    serreg_port i_serreg_port (
        .clk(clk), .rst_n(rst_n), .chain_mode(chain_mode), .sclk(sclk),
        .latch_n(latch_n), .sdi(sdi), .sdo(sdo), .sdo_oe(sdo_oe), .regs_o(regs_o)
    );

    int checks = 0, errors = 0;
    logic [DATA_W-1:0] model [NREG];
    logic [31:0] seen;

    task automatic check(input bit ok, input string req,
                         input logic [NREG*DATA_W-1:0] act, input logic [NREG*DATA_W-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] mk(input int a, input logic rd, input logic [9:0] d);
        return {4'(a), rd, 1'b0, d};
    endfunction

    task automatic check_bank(input string req);
        logic [NREG*DATA_W-1:0] e;
        for (int a = 0; a < NREG; a++) e[a*DATA_W +: DATA_W] = model[a];
        check(regs_o == e, req, regs_o, e);
    endtask

    task automatic frame(input logic [31:0] w, input int nbits, output logic [31:0] got);
        got = '0;
        latch_n = 1'b0;
        repeat (H) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            sdi = w[nbits-1-i];
            repeat (H) @(negedge clk);
            got[nbits-1-i] = sdo;
            sclk = 1'b1;
            repeat (H) @(negedge clk);
            sclk = 1'b0;
            repeat (H) @(negedge clk);
        end
        latch_n = 1'b1;
        repeat (2*H) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual hung expected done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int a = 0; a < NREG; a++) model[a] = '0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R1 reset state
        check_bank("R1");
        check(sdo_oe == 1'b0, "R1", 160'(sdo_oe), 160'(0));

        // R2 / R3 write sweep
        for (int a = 0; a < NREG; a++) begin
            logic [9:0] v;
            v = 10'((a*97 + 3) & 10'h1FF);
            frame(32'(mk(a, 1'b0, v)), 16, seen);
            if (!RSV[a]) model[a] = v;
            check_bank(RSV[a] ? "R3" : "R2");
        end

        // R4 / R3 readback sweep, each frame returns the previous read
        for (int a = 0; a <= NREG; a++) begin
            frame(32'(a < NREG ? mk(a, 1'b1, '0) : mk(15, 1'b0, '0)), 16, seen);
            if (a > 0) begin
                logic [15:0] e;
                e = mk(a-1, 1'b1, RSV[a-1] ? 10'h0 : model[a-1]);
                check(seen[15:0] == e, RSV[a-1] ? "R3" : "R4", 160'(seen[15:0]), 160'(e));
            end
        end

        // R5 wrong length in shared-bus mode
        frame(32'(mk(1, 1'b0, 10'h2AA)) >> 1, 15, seen);
        check_bank("R5");
        frame(32'(mk(1, 1'b0, 10'h2AA)), 17, seen);
        check_bank("R5");

        // R6 activity while deselected
        for (int i = 0; i < 24; i++) begin
            sdi = 1'(i ^ (i >> 2));
            sclk = ~sclk;
            repeat (H) @(negedge clk);
        end
        sclk = 1'b0;
        repeat (H) @(negedge clk);
        check(sdo_oe == 1'b0, "R6", 160'(sdo_oe), 160'(0));
        check_bank("R6");
        frame(32'(mk(2, 1'b0, 10'h155)), 16, seen);
        model[2] = 10'h155;
        check_bank("R6");

        // R7 output enable follows select; empty frame discarded (R5)
        latch_n = 1'b0;
        repeat (H) @(negedge clk);
        check(sdo_oe == 1'b1, "R7", 160'(sdo_oe), 160'(1));
        latch_n = 1'b1;
        repeat (2*H) @(negedge clk);
        check(sdo_oe == 1'b0, "R7", 160'(sdo_oe), 160'(0));
        check_bank("R5");

        // R8 chained mode
        chain_mode = 1'b1;
        repeat (2) @(negedge clk);
        check(sdo_oe == 1'b1, "R8", 160'(sdo_oe), 160'(1));
        frame({mk(3, 1'b0, 10'h0F0), mk(4, 1'b0, 10'h30C)}, 32, seen);
        model[4] = 10'h30C;
        check_bank("R8");
        check(seen[15:0] == mk(3, 1'b0, 10'h0F0), "R8", 160'(seen[15:0]), 160'(mk(3, 1'b0, 10'h0F0)));
        check(seen[31:16] == 16'h0, "R4", 160'(seen[31:16]), 160'(0));
        frame(32'(mk(5, 1'b0, 10'h0A5)), 17, seen);
        model[5] = 10'h0A5;
        check_bank("R8");
        frame(32'(mk(6, 1'b0, 10'h001)) >> 1, 15, seen);
        check_bank("R8");
        frame(32'(mk(4, 1'b1, '0)), 16, seen);
        frame(32'(mk(15, 1'b0, '0)), 16, seen);
        check(seen[15:0] == mk(4, 1'b1, 10'h30C), "R4", 160'(seen[15:0]), 160'(mk(4, 1'b1, 10'h30C)));

        // R9 software reset
        chain_mode = 1'b0;
        repeat (2) @(negedge clk);
        frame(32'(mk(0, 1'b0, 10'h200)), 16, seen);
        for (int a = 0; a < NREG; a++) model[a] = '0;
        check_bank("R9");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule